// File: doc/BRIEF.md
# Power-fail memory access gate

This block sits between a host's active-low chip-enable and write-enable strobes and a battery-backed SRAM. An external comparator supplies a digital flag that says whether the supply is in tolerance. While that flag is high, the strobes pass through to the memory. When the flag drops, the block lets a chip-enable or write-enable that is already low finish. It then drives both memory strobes inactive and keeps them there for as long as the supply stays bad. Each strobe is released either when its own input rises or when a bounded hold window runs out, whichever happens first. An active-low power-fail flag reports the supply state.

When the supply returns, the strobes stay inactive for a recovery interval. Only after that does normal operation resume. The block also takes the battery status from the external monitor. On the way up from a power loss, it decides whether the backup cells were healthy:

- If no switchover happened during backup, only the cell in use is judged.
- If a switchover happened, both cells are judged.

When a judged cell was weak, the block withholds exactly the second chip-enable cycle after power-up. Software can then detect the problem by writing a location and reading it back.

The hold window and the recovery interval are set in clock cycles from the clock frequency in MHz, a hold time in ns and a recovery time in µs. All strobe and supply inputs are brought into the clock domain through two-flop synchronisers.

Top module: `pfgate`

## Requirements
- R1: While running normally, `ce_n_o` equals `ce_n_i` and `we_n_o` equals `we_n_i`. The input value appears at the outputs on the third rising clock edge after it is applied.
- R2: When the synchronised supply flag falls and `ce_n_i` is low, `ce_n_o` stays low until the synchronised `ce_n_i` is high. It is forced high no later than HOLD_CYC cycles after the hold window opens: it is still low at clock edge 2+HOLD_CYC and high at clock edge 3+HOLD_CYC, both counted from the first edge that samples the dropped flag.
- R3: `we_n_o` obeys the same hold rule as R2 on its own. It is released by `we_n_i` rising or by the hold timeout, and it does not depend on the chip-enable.
- R4: Once released after a failure, `ce_n_o` and `we_n_o` stay high whatever the inputs do, for as long as the supply flag stays low.
- R5: `pf_n_o` equals the value `supply_ok_i` had three clock edges earlier (low means failed).
- R6: After the synchronised supply flag rises, both strobes stay high for REC_CYC cycles. With the strobe inputs held low, the outputs are still high at clock edge 3+REC_CYC and low at clock edge 4+REC_CYC, both counted from the first edge that samples the raised flag.
- R7: At power-up the battery is judged bad as follows:
  - if `bat_swap_i` is 1: when `bat0_low_i` or `bat1_low_i` is 1;
  - if `bat_swap_i` is 0: when the low flag of the cell named by `bat_sel_i` is 1 (0 selects cell 0, 1 selects cell 1).
- R8: When the battery is judged bad, the second falling edge of `ce_n_i` after recovery produces no low on `ce_n_o`. The first and third cycles pass. When the battery is judged good, all cycles pass.
- R9: While `rst` is high, `ce_n_o` and `we_n_o` are 1 and `pf_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply in tolerance, from the external comparator |
| ce_n_i | input | 1 | Host chip-enable, active low |
| we_n_i | input | 1 | Host write-enable, active low |
| bat_swap_i | input | 1 | A cell-to-cell switchover happened during backup |
| bat_sel_i | input | 1 | Cell that supplied the backup (0 or 1) |
| bat0_low_i | input | 1 | Cell 0 is below the health threshold |
| bat1_low_i | input | 1 | Cell 1 is below the health threshold |
| ce_n_o | output | 1 | Chip-enable to the memory, active low |
| we_n_o | output | 1 | Write-enable to the memory, active low |
| pf_n_o | output | 1 | Power-fail flag, low while the supply is out of tolerance |

## Verification
The bench builds the block with CLK_MHZ=100, HOLD_NS=200 and REC_US=1. This gives a 20-cycle hold window and a 100-cycle recovery interval, so exact edge positions of both timeouts can be checked. These short intervals also make it cheap to run a full power cycle for every one of the 16 combinations of the four battery-status inputs. For each combination, the bench drives three chip-enable cycles and compares each against the suppression rule computed from those inputs. Hold release by a rising input, release by timeout and strobe pass-through over all four strobe combinations are each checked separately.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [1:0] {
        ST_DOWN    = 2'd0,
        ST_RECOVER = 2'd1,
        ST_RUN     = 2'd2,
        ST_DRAIN   = 2'd3
    } pfg_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
    } strobe_t;

    function automatic logic cell_bad(input logic swap, input logic sel,
                                      input logic low0, input logic low1);
        if (swap) begin
            return low0 | low1;
        end
        return sel ? low1 : low0;
    endfunction

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q_o  <= RST_VAL;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end
endmodule

// File: rtl/pfg_batt.sv
module pfg_batt (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic run_i,
    input  logic ce_s_i,
    input  logic swap_i,
    input  logic sel_i,
    input  logic low0_i,
    input  logic low1_i,
    output logic supp_o
);
    import pfg_pkg::*;

    logic       bad_q;
    logic [1:0] cyc_q;
    logic       blk_q;
    logic       ce_prev_q;
    logic       ce_fall;

    assign ce_fall = ce_prev_q & ~ce_s_i;

    always_comb begin
        supp_o = (run_i && ce_fall && cyc_q == 2'd1 && bad_q) || (blk_q && !ce_s_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_q     <= 1'b0;
            cyc_q     <= 2'd0;
            blk_q     <= 1'b0;
            ce_prev_q <= 1'b1;
        end else begin
            ce_prev_q <= ce_s_i;
            if (arm_i) begin
                bad_q <= cell_bad(swap_i, sel_i, low0_i, low1_i);
                cyc_q <= 2'd0;
                blk_q <= 1'b0;
            end else begin
                blk_q <= run_i && supp_o;
                if (run_i && ce_fall && cyc_q != 2'd2) begin
                    cyc_q <= cyc_q + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/pfg_seq.sv
module pfg_seq #(
    parameter int HOLD_CYC = 150,
    parameter int REC_CYC  = 15000000
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_s_i,
    input  pfg_pkg::strobe_t stb_s_i,
    input  logic supp_i,
    output logic arm_o,
    output logic run_o,
    output logic ce_n_o,
    output logic we_n_o,
    output logic pf_n_o
);
    import pfg_pkg::*;

    localparam int HOLD_W = $clog2(HOLD_CYC + 1);
    localparam int REC_W  = $clog2(REC_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);
    localparam logic [REC_W-1:0]  REC_LAST  = REC_W'(REC_CYC - 1);

    pfg_state_e        state_q;
    logic [HOLD_W-1:0] hold_q;
    logic [REC_W-1:0]  rec_q;
    logic              tmo;
    logic              ce_hold_nx;
    logic              we_hold_nx;

    always_comb begin
        tmo        = (hold_q == HOLD_LAST);
        ce_hold_nx = ce_n_o | stb_s_i.ce_n | tmo;
        we_hold_nx = we_n_o | stb_s_i.we_n | tmo;
        arm_o      = (state_q == ST_DOWN) && sup_s_i;
        run_o      = (state_q == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DOWN;
            hold_q  <= '0;
            rec_q   <= '0;
            ce_n_o  <= 1'b1;
            we_n_o  <= 1'b1;
            pf_n_o  <= 1'b0;
        end else begin
            pf_n_o <= sup_s_i;
            case (state_q)
                ST_DOWN: begin
                    ce_n_o <= 1'b1;
                    we_n_o <= 1'b1;
                    rec_q  <= '0;
                    if (sup_s_i) begin
                        state_q <= ST_RECOVER;
                    end
                end
                ST_RECOVER: begin
                    ce_n_o <= 1'b1;
                    we_n_o <= 1'b1;
                    if (!sup_s_i) begin
                        state_q <= ST_DOWN;
                    end else if (rec_q == REC_LAST) begin
                        state_q <= ST_RUN;
                    end else begin
                        rec_q <= rec_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    ce_n_o <= stb_s_i.ce_n | supp_i;
                    we_n_o <= stb_s_i.we_n;
                    hold_q <= '0;
                    if (!sup_s_i) begin
                        state_q <= ST_DRAIN;
                    end
                end
                default: begin
                    ce_n_o <= ce_hold_nx;
                    we_n_o <= we_hold_nx;
                    if (!tmo) begin
                        hold_q <= hold_q + 1'b1;
                    end
                    if (ce_hold_nx && we_hold_nx) begin
                        state_q <= ST_DOWN;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pfgate.sv
module pfgate #(
    parameter int CLK_MHZ = 100,
    parameter int HOLD_NS = 1500,
    parameter int REC_US  = 150000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok_i,
    input  logic ce_n_i,
    input  logic we_n_i,
    input  logic bat_swap_i,
    input  logic bat_sel_i,
    input  logic bat0_low_i,
    input  logic bat1_low_i,
    output logic ce_n_o,
    output logic we_n_o,
    output logic pf_n_o
);
    import pfg_pkg::*;

    localparam int HOLD_CYC = (CLK_MHZ * HOLD_NS + 999) / 1000;
    localparam int REC_CYC  = CLK_MHZ * REC_US;

    strobe_t stb_raw;
    strobe_t stb_s;
    logic    sup_s;
    logic    arm;
    logic    run;
    logic    supp;

    assign stb_raw.ce_n = ce_n_i;
    assign stb_raw.we_n = we_n_i;

    pfg_sync #(.W(2), .RST_VAL(2'b11)) u_sync_stb (
        .clk (clk),
        .rst (rst),
        .d_i (stb_raw),
        .q_o (stb_s)
    );

    pfg_sync #(.W(1), .RST_VAL(1'b0)) u_sync_sup (
        .clk (clk),
        .rst (rst),
        .d_i (supply_ok_i),
        .q_o (sup_s)
    );

    pfg_batt u_batt (
        .clk    (clk),
        .rst    (rst),
        .arm_i  (arm),
        .run_i  (run),
        .ce_s_i (stb_s.ce_n),
        .swap_i (bat_swap_i),
        .sel_i  (bat_sel_i),
        .low0_i (bat0_low_i),
        .low1_i (bat1_low_i),
        .supp_o (supp)
    );

    pfg_seq #(.HOLD_CYC(HOLD_CYC), .REC_CYC(REC_CYC)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .sup_s_i (sup_s),
        .stb_s_i (stb_s),
        .supp_i  (supp),
        .arm_o   (arm),
        .run_o   (run),
        .ce_n_o  (ce_n_o),
        .we_n_o  (we_n_o),
        .pf_n_o  (pf_n_o)
    );
endmodule

// File: rtl/pfgate_chk.sv
module pfgate_chk #(
    parameter int HOLD_CYC = 150
) (
    input logic clk,
    input logic rst,
    input logic supply_ok_i,
    input logic ce_n_o,
    input logic we_n_o,
    input logic pf_n_o
);
    localparam int CW = $clog2(HOLD_CYC + 4);

    logic [1:0]    age_q;
    logic [CW-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= 2'd0;
            low_q <= '0;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
            if (!pf_n_o && !ce_n_o) begin
                if (low_q != {CW{1'b1}}) low_q <= low_q + 1'b1;
            end else begin
                low_q <= '0;
            end
        end
    end

    // R2: chip-enable low during a failure never outlasts the hold window
    p_hold_limit_r2: assert property (@(posedge clk) disable iff (rst)
        low_q <= CW'(HOLD_CYC + 2));

    // R4: once released during a failure, the chip-enable stays high
    p_ce_stays_r4: assert property (@(posedge clk) disable iff (rst)
        (!pf_n_o && ce_n_o) |=> ce_n_o);

    // R4: once released during a failure, the write-enable stays high
    p_we_stays_r4: assert property (@(posedge clk) disable iff (rst)
        (!pf_n_o && we_n_o) |=> we_n_o);

    // R5: the power-fail flag tracks the supply input three edges late
    p_pf_track_r5: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) |-> (pf_n_o == $past(supply_ok_i, 3)));

    // R6: when power returns, both strobes are held inactive
    p_rec_hold_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_n_o) |-> (ce_n_o && we_n_o));
endmodule

bind pfgate pfgate_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .supply_ok_i (supply_ok_i),
    .ce_n_o      (ce_n_o),
    .we_n_o      (we_n_o),
    .pf_n_o      (pf_n_o)
);

// File: tb/pfgate_tb.sv
module pfgate_tb;
    localparam int H = 20;
    localparam int R = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic supply_ok_i = 1'b0;
    logic ce_n_i = 1'b1;
    logic we_n_i = 1'b1;
    logic bat_swap_i = 1'b0;
    logic bat_sel_i = 1'b0;
    logic bat0_low_i = 1'b0;
    logic bat1_low_i = 1'b0;
    logic ce_n_o, we_n_o, pf_n_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pfgate #(.CLK_MHZ(100), .HOLD_NS(200), .REC_US(1)) u_dut (
        .clk(clk), .rst(rst), .supply_ok_i(supply_ok_i),
        .ce_n_i(ce_n_i), .we_n_i(we_n_i),
        .bat_swap_i(bat_swap_i), .bat_sel_i(bat_sel_i),
        .bat0_low_i(bat0_low_i), .bat1_low_i(bat1_low_i),
        .ce_n_o(ce_n_o), .we_n_o(we_n_o), .pf_n_o(pf_n_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic power_down();
        @(negedge clk);
        supply_ok_i = 1'b0;
        edges(H + 8);
    endtask

    task automatic power_up(input logic [3:0] b);
        @(negedge clk);
        {bat_swap_i, bat_sel_i, bat1_low_i, bat0_low_i} = b;
        supply_ok_i = 1'b1;
        edges(R + 8);
    endtask

    initial begin
        edges(2);
        chk("R9", "ce_n_o in reset", ce_n_o, 1'b1);
        chk("R9", "we_n_o in reset", we_n_o, 1'b1);
        chk("R9", "pf_n_o in reset", pf_n_o, 1'b0);
        rst = 1'b0;
        edges(3);

        // R6: recovery hold with both strobes requested low
        ce_n_i = 1'b0;
        we_n_i = 1'b0;
        supply_ok_i = 1'b1;
        edges(2);
        edges(R + 1);
        chk("R6", "ce_n_o at end of recovery", ce_n_o, 1'b1);
        chk("R6", "we_n_o at end of recovery", we_n_o, 1'b1);
        edges(1);
        chk("R6", "ce_n_o after recovery", ce_n_o, 1'b0);
        chk("R6", "we_n_o after recovery", we_n_o, 1'b0);
        chk("R5", "pf_n_o with good supply", pf_n_o, 1'b1);
        ce_n_i = 1'b1;
        we_n_i = 1'b1;
        edges(5);

        // R1: all strobe combinations
        for (int i = 0; i < 4; i++) begin
            {ce_n_i, we_n_i} = i[1:0];
            edges(2);
            chk("R1", "ce_n_o before third edge", ce_n_o, 1'b1);
            edges(1);
            chk("R1", "ce_n_o pass", ce_n_o, i[1]);
            chk("R1", "we_n_o pass", we_n_o, i[0]);
            ce_n_i = 1'b1;
            we_n_i = 1'b1;
            edges(4);
        end

        // R2: chip-enable held through failure until timeout
        ce_n_i = 1'b0;
        edges(4);
        supply_ok_i = 1'b0;
        edges(H + 2);
        chk("R2", "ce_n_o held in window", ce_n_o, 1'b0);
        chk("R5", "pf_n_o after failure", pf_n_o, 1'b0);
        edges(1);
        chk("R2", "ce_n_o forced at timeout", ce_n_o, 1'b1);
        ce_n_i = 1'b1;
        edges(4);
        ce_n_i = 1'b0;
        we_n_i = 1'b0;
        edges(5);
        chk("R4", "ce_n_o stays high", ce_n_o, 1'b1);
        chk("R4", "we_n_o stays high", we_n_o, 1'b1);
        ce_n_i = 1'b1;
        we_n_i = 1'b1;
        power_up(4'b0000);

        // R3: write-enable held then released by its input
        we_n_i = 1'b0;
        edges(4);
        supply_ok_i = 1'b0;
        edges(5);
        chk("R3", "ce_n_o released at once", ce_n_o, 1'b1);
        chk("R3", "we_n_o held", we_n_o, 1'b0);
        we_n_i = 1'b1;
        edges(4);
        chk("R3", "we_n_o released by input", we_n_o, 1'b1);
        power_up(4'b0000);

        // R2: chip-enable released early by its input
        ce_n_i = 1'b0;
        edges(4);
        supply_ok_i = 1'b0;
        edges(5);
        chk("R2", "ce_n_o held before release", ce_n_o, 1'b0);
        ce_n_i = 1'b1;
        edges(4);
        chk("R2", "ce_n_o released by input", ce_n_o, 1'b1);
        edges(H);

        // R7 / R8: every battery status combination
        for (int b = 0; b < 16; b++) begin
            logic bad;
            logic [3:0] bv;
            bv = b[3:0];
            bad = bv[3] ? (bv[0] | bv[1]) : (bv[2] ? bv[1] : bv[0]);
            power_down();
            power_up(bv);
            for (int k = 0; k < 3; k++) begin
                ce_n_i = 1'b0;
                edges(4);
                chk((k == 1) ? "R7" : "R8", "ce_n_o in cycle",
                    ce_n_o, (k == 1) ? bad : 1'b0);
                ce_n_i = 1'b1;
                edges(4);
                chk("R8", "ce_n_o idle between cycles", ce_n_o, 1'b1);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule